// File: doc/BRIEF.md
# Register Stack Frame Marker Unit

This block holds the marker that describes the current frame of a stacked general-register file. The marker is one 38-bit word. It carries the frame size, the size of the locals portion, the size of the rotating portion (counted in groups of eight registers) and three rename-base values, one each for the general, floating-point and predicate register classes. A single saved copy of the marker sits alongside it.

The marker changes only through four events. A call saves the marker and opens a fresh frame that holds nothing but the caller's outputs. A return brings the saved marker back. An allocate request installs new frame, locals and rotating sizes, or refuses them when they do not fit. A rotate strobe for a register class steps that class's rename base down by one, wrapping inside its rotating region. Rename logic elsewhere reads the marker fields and the rotating-register count from the outputs.

Top module: `fmark_unit`

## Requirements
- R1: While reset is low and after its release, the marker output, the saved copy and the error flag are all zero.
- R2: The marker word places the frame size in bits 6:0, locals size in 13:7, rotating size in 17:14, general rename base in 24:18, floating-point rename base in 31:25 and predicate rename base in 37:32; each field port equals its slice; the rotating count output is 8 times the rotating size.
- R3: A call copies the whole current marker unchanged into the saved copy.
- R4: After a call the frame size is the old frame size minus the old locals size, and the locals size, rotating size and all three rename bases are zero.
- R5: A return (without a call in the same cycle) makes the marker equal to the saved copy; the saved copy is left as it was.
- R6: An accepted allocate writes the requested frame, locals and rotating sizes, sets the general rename base to zero, keeps the floating-point and predicate rename bases, and leaves the error flag low.
- R7: An allocate whose locals size exceeds its frame size, or whose 8 times rotating size exceeds its frame size, leaves the marker unchanged and raises the error flag for exactly the next cycle.
- R8: A general rotate strobe decrements the general rename base, wrapping from 0 to 8*rotating size minus 1; with rotating size zero the base stays zero.
- R9: A floating-point rotate strobe decrements its base modulo 96 (0 wraps to 95); a predicate rotate strobe decrements its base modulo 48 (0 wraps to 47); strobes of different classes in one cycle all take effect.
- R10: When events coincide, call wins over return, return over allocate, and allocate over rotate; the losing events of that cycle have no effect, and an ignored bad allocate raises no error.
- R11: The general rename base always stays below the rotating count (or at zero when that count is zero), the floating-point base below 96 and the predicate base below 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call event |
| ret_i | input | 1 | Procedure return event |
| alloc_i | input | 1 | Allocate request |
| alloc_sof_i | input | 7 | Requested frame size |
| alloc_sol_i | input | 7 | Requested locals size |
| alloc_sor_i | input | 4 | Requested rotating size, in groups of eight |
| rot_gr_i | input | 1 | Rotate step for the general class |
| rot_fr_i | input | 1 | Rotate step for the floating-point class |
| rot_pr_i | input | 1 | Rotate step for the predicate class |
| cfm_o | output | 38 | Current marker word |
| frame_sz_o | output | 7 | Frame size field |
| locals_sz_o | output | 7 | Locals size field |
| rot_sz_o | output | 4 | Rotating size field |
| gr_base_o | output | 7 | General rename base |
| fr_base_o | output | 7 | Floating-point rename base |
| pr_base_o | output | 6 | Predicate rename base |
| rot_count_o | output | 7 | Number of rotating general registers |
| alloc_err_o | output | 1 | Allocate rejected in the previous cycle |

## Verification
The bench drives the rename bases through their wrap points: the general base past zero with a rotating region of two groups, the floating-point base over a hundred steps and the predicate base over fifty; a wrong modulus shows up as a base that lands on 127, 63 or an out-of-range value. It presses allocate on both refusal conditions and on the exact boundary where locals and rotating sizes equal the frame size, where an off-by-one compare would either refuse a legal frame or accept a bad one. Colliding events check the priority order, a design that let a lower event through would alter the marker or raise a stray error. A call followed by a return checks that the saved copy is whole, since a lost field would come back as zero.

// File: rtl/fmark_pkg.sv
package fmark_pkg;
    localparam int SOF_W    = 7;
    localparam int SOL_W    = 7;
    localparam int SOR_W    = 4;
    localparam int GRB_W    = 7;
    localparam int FRB_W    = 7;
    localparam int PRB_W    = 6;
    localparam int ROT_GRAN = 8;
    localparam int ROT_SH   = $clog2(ROT_GRAN);
    localparam int CNT_W    = SOR_W + ROT_SH;
    localparam int MARK_W   = SOF_W + SOL_W + SOR_W + GRB_W + FRB_W + PRB_W;
    localparam int FR_ROT   = 96;
    localparam int PR_ROT   = 48;

    typedef struct packed {
        logic [PRB_W-1:0] pr_base;
        logic [FRB_W-1:0] fr_base;
        logic [GRB_W-1:0] gr_base;
        logic [SOR_W-1:0] rot_sz;
        logic [SOL_W-1:0] loc_sz;
        logic [SOF_W-1:0] frm_sz;
    } marker_t;

    typedef struct packed {
        marker_t cfm;
        marker_t pfm;
        logic    err;
    } fm_state_t;
endpackage

// File: rtl/fmark_rotator.sv
module fmark_rotator #(
    parameter int W = 7
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] mod_i,
    input  logic         step_i,
    output logic [W-1:0] base_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (!step_i || mod_i == '0) begin
            base_o = base_i;
        end else if (base_i == '0) begin
            base_o = mod_i - ONE;
        end else begin
            base_o = base_i - ONE;
        end
    end
endmodule

// File: rtl/fmark_alloc_check.sv
module fmark_alloc_check
    import fmark_pkg::*;
(
    input  logic [SOF_W-1:0] sof_i,
    input  logic [SOL_W-1:0] sol_i,
    input  logic [SOR_W-1:0] sor_i,
    output logic             ok_o
);
    logic [CNT_W-1:0] rot_regs;
    logic             loc_fit;
    logic             rot_fit;

    always_comb begin
        rot_regs = {sor_i, {ROT_SH{1'b0}}};
        loc_fit  = ({1'b0, sol_i} <= {1'b0, sof_i});
        rot_fit  = ({1'b0, rot_regs} <= {1'b0, sof_i});
        ok_o     = loc_fit && rot_fit;
    end
endmodule

// File: rtl/fmark_unit.sv
module fmark_unit
    import fmark_pkg::*;
#(
    parameter int FR_MOD = FR_ROT,
    parameter int PR_MOD = PR_ROT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              alloc_i,
    input  logic [SOF_W-1:0]  alloc_sof_i,
    input  logic [SOL_W-1:0]  alloc_sol_i,
    input  logic [SOR_W-1:0]  alloc_sor_i,
    input  logic              rot_gr_i,
    input  logic              rot_fr_i,
    input  logic              rot_pr_i,
    output logic [MARK_W-1:0] cfm_o,
    output logic [SOF_W-1:0]  frame_sz_o,
    output logic [SOL_W-1:0]  locals_sz_o,
    output logic [SOR_W-1:0]  rot_sz_o,
    output logic [GRB_W-1:0]  gr_base_o,
    output logic [FRB_W-1:0]  fr_base_o,
    output logic [PRB_W-1:0]  pr_base_o,
    output logic [CNT_W-1:0]  rot_count_o,
    output logic              alloc_err_o
);
    localparam logic [FRB_W-1:0] FR_MOD_V = FRB_W'(FR_MOD);
    localparam logic [PRB_W-1:0] PR_MOD_V = PRB_W'(PR_MOD);

    fm_state_t st_d, st_q;

    logic [CNT_W-1:0] rot_regs;
    logic [GRB_W-1:0] gr_nxt;
    logic [FRB_W-1:0] fr_nxt;
    logic [PRB_W-1:0] pr_nxt;
    logic             alloc_ok;

    assign rot_regs = {st_q.cfm.rot_sz, {ROT_SH{1'b0}}};

    fmark_rotator #(.W(GRB_W)) i_rot_gr (
        .base_i (st_q.cfm.gr_base),
        .mod_i  (GRB_W'(rot_regs)),
        .step_i (rot_gr_i),
        .base_o (gr_nxt)
    );

    fmark_rotator #(.W(FRB_W)) i_rot_fr (
        .base_i (st_q.cfm.fr_base),
        .mod_i  (FR_MOD_V),
        .step_i (rot_fr_i),
        .base_o (fr_nxt)
    );

    fmark_rotator #(.W(PRB_W)) i_rot_pr (
        .base_i (st_q.cfm.pr_base),
        .mod_i  (PR_MOD_V),
        .step_i (rot_pr_i),
        .base_o (pr_nxt)
    );

    fmark_alloc_check i_chk_alloc (
        .sof_i (alloc_sof_i),
        .sol_i (alloc_sol_i),
        .sor_i (alloc_sor_i),
        .ok_o  (alloc_ok)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (call_i) begin
            st_d.pfm        = st_q.cfm;
            st_d.cfm        = '0;
            st_d.cfm.frm_sz = st_q.cfm.frm_sz - st_q.cfm.loc_sz;
        end else if (ret_i) begin
            st_d.cfm = st_q.pfm;
        end else if (alloc_i) begin
            if (alloc_ok) begin
                st_d.cfm.frm_sz  = alloc_sof_i;
                st_d.cfm.loc_sz  = alloc_sol_i;
                st_d.cfm.rot_sz  = alloc_sor_i;
                st_d.cfm.gr_base = '0;
            end else begin
                st_d.err = 1'b1;
            end
        end else begin
            st_d.cfm.gr_base = gr_nxt;
            st_d.cfm.fr_base = fr_nxt;
            st_d.cfm.pr_base = pr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfm_o       = st_q.cfm;
    assign frame_sz_o  = st_q.cfm.frm_sz;
    assign locals_sz_o = st_q.cfm.loc_sz;
    assign rot_sz_o    = st_q.cfm.rot_sz;
    assign gr_base_o   = st_q.cfm.gr_base;
    assign fr_base_o   = st_q.cfm.fr_base;
    assign pr_base_o   = st_q.cfm.pr_base;
    assign rot_count_o = rot_regs;
    assign alloc_err_o = st_q.err;
endmodule

// File: rtl/fmark_chk.sv
module fmark_chk
    import fmark_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic              ret_i,
    input logic              alloc_i,
    input logic [SOF_W-1:0]  alloc_sof_i,
    input logic [SOL_W-1:0]  alloc_sol_i,
    input logic [SOR_W-1:0]  alloc_sor_i,
    input logic [MARK_W-1:0] cfm_o,
    input logic              alloc_err_o,
    input logic [MARK_W-1:0] pfm_i
);
    marker_t m;
    logic    bad_req;

    assign m       = cfm_o;
    assign bad_req = (int'(alloc_sol_i) > int'(alloc_sof_i)) ||
                     (int'(alloc_sor_i) * ROT_GRAN > int'(alloc_sof_i));

    a_r3_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
        call_i |=> pfm_i == $past(cfm_o));

    a_r4_call_frame: assert property (@(posedge clk) disable iff (!rst_n)
        call_i |=> (m.loc_sz == '0 && m.rot_sz == '0 && m.gr_base == '0 &&
                    m.fr_base == '0 && m.pr_base == '0 &&
                    m.frm_sz == $past(m.frm_sz - m.loc_sz)));

    a_r5_ret_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i) |=> (cfm_o == $past(pfm_i) && $stable(pfm_i)));

    a_r7_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !call_i && !ret_i && bad_req) |=> (alloc_err_o && $stable(cfm_o)));

    a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_err_o |-> ($past(alloc_i) && !$past(call_i) && !$past(ret_i)));

    a_r11_gr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (m.rot_sz == '0) ? (m.gr_base == '0)
                         : (int'(m.gr_base) < int'(m.rot_sz) * ROT_GRAN));

    a_r11_fr_pr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(m.fr_base) < FR_ROT) && (int'(m.pr_base) < PR_ROT));
endmodule

bind fmark_unit fmark_chk i_fmark_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .alloc_i     (alloc_i),
    .alloc_sof_i (alloc_sof_i),
    .alloc_sol_i (alloc_sol_i),
    .alloc_sor_i (alloc_sor_i),
    .cfm_o       (cfm_o),
    .alloc_err_o (alloc_err_o),
    .pfm_i       (st_q.pfm)
);

// File: tb/test_fmark_unit.sv
module test_fmark_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, alloc_i = 0;
    logic [6:0]  alloc_sof_i = 0, alloc_sol_i = 0;
    logic [3:0]  alloc_sor_i = 0;
    logic        rot_gr_i = 0, rot_fr_i = 0, rot_pr_i = 0;
    logic [37:0] cfm_o;
    logic [6:0]  frame_sz_o, locals_sz_o, gr_base_o, fr_base_o, rot_count_o;
    logic [3:0]  rot_sz_o;
    logic [5:0]  pr_base_o;
    logic        alloc_err_o;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R1";
    string last_tag = "R1";

    // reference model state
    int e_sof = 0, e_sol = 0, e_sor = 0, e_gr = 0, e_fr = 0, e_pr = 0;
    int p_sof = 0, p_sol = 0, p_sor = 0, p_gr = 0, p_fr = 0, p_pr = 0;
    int e_err = 0;

    fmark_unit i_fmark_unit (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .alloc_i(alloc_i), .alloc_sof_i(alloc_sof_i), .alloc_sol_i(alloc_sol_i),
        .alloc_sor_i(alloc_sor_i), .rot_gr_i(rot_gr_i), .rot_fr_i(rot_fr_i),
        .rot_pr_i(rot_pr_i), .cfm_o(cfm_o), .frame_sz_o(frame_sz_o),
        .locals_sz_o(locals_sz_o), .rot_sz_o(rot_sz_o), .gr_base_o(gr_base_o),
        .fr_base_o(fr_base_o), .pr_base_o(pr_base_o), .rot_count_o(rot_count_o),
        .alloc_err_o(alloc_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        last_tag = cur_tag;
        e_err = 0;
        if (!rst_n) begin
            {e_sof, e_sol, e_sor, e_gr, e_fr, e_pr} = {6{32'sd0}};
            {p_sof, p_sol, p_sor, p_gr, p_fr, p_pr} = {6{32'sd0}};
        end else if (call_i) begin
            {p_sof, p_sol, p_sor, p_gr, p_fr, p_pr} = {e_sof, e_sol, e_sor, e_gr, e_fr, e_pr};
            e_sof = e_sof - e_sol;
            {e_sol, e_sor, e_gr, e_fr, e_pr} = {5{32'sd0}};
        end else if (ret_i) begin
            {e_sof, e_sol, e_sor, e_gr, e_fr, e_pr} = {p_sof, p_sol, p_sor, p_gr, p_fr, p_pr};
        end else if (alloc_i) begin
            if (int'(alloc_sol_i) > int'(alloc_sof_i) || 8 * int'(alloc_sor_i) > int'(alloc_sof_i)) begin
                e_err = 1;
            end else begin
                e_sof = alloc_sof_i; e_sol = alloc_sol_i; e_sor = alloc_sor_i; e_gr = 0;
            end
        end else begin
            if (rot_gr_i && e_sor != 0) e_gr = (e_gr == 0) ? 8 * e_sor - 1 : e_gr - 1;
            if (rot_fr_i) e_fr = (e_fr == 0) ? 95 : e_fr - 1;
            if (rot_pr_i) e_pr = (e_pr == 0) ? 47 : e_pr - 1;
        end
    end

    function automatic logic [37:0] exp_word();
        return {6'(e_pr), 7'(e_fr), 7'(e_gr), 4'(e_sor), 7'(e_sol), 7'(e_sof)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(cfm_o == exp_word(), last_tag, "marker", longint'(cfm_o), longint'(exp_word()));
            check(alloc_err_o == e_err[0], last_tag, "alloc_err", longint'(alloc_err_o), longint'(e_err));
            check({pr_base_o, fr_base_o, gr_base_o, rot_sz_o, locals_sz_o, frame_sz_o} == exp_word()
                  && int'(rot_count_o) == 8 * e_sor, "R2", "fields",
                  longint'(rot_count_o), longint'(8 * e_sor));
        end
    end

    task automatic ev(input bit c, input bit r, input bit a, input int sof, input int sol,
                      input int sor, input bit g, input bit f, input bit p, input string tag);
        call_i = c; ret_i = r; alloc_i = a;
        alloc_sof_i = 7'(sof); alloc_sol_i = 7'(sol); alloc_sor_i = 4'(sor);
        rot_gr_i = g; rot_fr_i = f; rot_pr_i = p;
        cur_tag = tag;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        ev(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cfm_o == '0 && alloc_err_o == 1'b0, "R1", "reset", longint'(cfm_o), 0);
        rst_n = 1'b1;
        idle("R1");
        // R6 accepted allocate with two rotating groups
        ev(0, 0, 1, 40, 10, 2, 0, 0, 0, "R6");
        // R8 general base wraps 0 -> 15
        for (int i = 0; i < 20; i++) ev(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
        // R9 floating-point and predicate wraps, also together
        for (int i = 0; i < 100; i++) ev(0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        for (int i = 0; i < 50; i++) ev(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 5; i++) ev(0, 0, 0, 0, 0, 0, 1, 1, 1, "R9");
        // R6 reallocate keeps fr/pr bases, clears gr base
        ev(0, 0, 1, 64, 20, 3, 0, 0, 0, "R6");
        // R7 rejections
        ev(0, 0, 1, 10, 20, 0, 0, 0, 0, "R7");
        ev(0, 0, 1, 20, 4, 3, 0, 0, 0, "R7");
        idle("R7");
        // R3 and R4 call, then R5 return
        ev(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 3; i++) ev(0, 0, 0, 0, 0, 0, 1, 1, 1, "R8");
        ev(0, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
        ev(0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
        // boundary: locals and rotating equal to frame
        ev(0, 0, 1, 16, 16, 2, 0, 0, 0, "R7");
        for (int i = 0; i < 18; i++) ev(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
        ev(0, 0, 1, 127, 7, 15, 0, 0, 0, "R6");
        for (int i = 0; i < 3; i++) ev(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
        // empty rotating region keeps gr base at zero
        ev(0, 0, 1, 30, 5, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) ev(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
        // R10 priority
        ev(1, 1, 1, 10, 20, 0, 1, 1, 1, "R10");
        ev(0, 1, 1, 10, 20, 0, 1, 1, 1, "R10");
        ev(0, 0, 1, 50, 0, 1, 1, 1, 1, "R10");
        ev(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        ev(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        ev(0, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle("R11");
        idle("R11");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule